// File: doc/BRIEF.md
# Data Register Load Extender

This block holds sixteen 40-bit accumulator-style data registers. Each register is split into an 8-bit extension (bits 39:32), a 16-bit high half (bits 31:16) and a 16-bit low half (bits 15:0). Each register also carries a 1-bit limit tag. Operands arriving from the memory data bus are written through a load port.

The load port carries a register index, an access size (byte, word or long), a fractional/integer flag, a signed/unsigned flag and 32 bits of data. The block places the operand in the correct part of the register, fills every other bit by sign or zero extension, and clears the tag.

A second write port, fed by the arithmetic unit, writes all 40 bits and the tag directly. It has priority over the load port when both address the same register in one cycle. Two independent combinational read ports return the full value and the tag. Read port A also presents a packed 9-bit view that holds the tag and the extension byte together.

Top module: `dreg_file`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every register value and every tag is cleared to zero at that edge.
- R2: A load with size code 2'b00 (byte) places `ld_data[7:0]` in bits 7:0. Bits 39:8 become copies of bit 7 when `ld_signed` is 1, or zeros when it is 0. The tag is cleared and `ld_frac` has no effect.
- R3: A load with size code 2'b01 (word) and `ld_frac`=0 places `ld_data[15:0]` in bits 15:0. Bits 39:16 are extended from bit 15, as sign or zero according to `ld_signed`. The tag is cleared.
- R4: A load with size code 2'b01 (word) and `ld_frac`=1 places `ld_data[15:0]` in bits 31:16 and zeros bits 15:0. Bits 39:32 are always copies of bit 31, whatever `ld_signed` says. The tag is cleared.
- R5: A load with size code 2'b10 (long) places `ld_data[31:0]` in bits 31:0. Bits 39:32 are extended from bit 31 according to `ld_signed`. The tag is cleared and `ld_frac` has no effect.
- R6: A load with size code 2'b11 changes no register value and no tag.
- R7: An arithmetic-port write (`alu_en`=1) stores `alu_data` and `alu_tag` unchanged into the addressed register at the next rising edge.
- R8: When both ports write the same register in one cycle, the register takes the arithmetic-port value and tag.
- R9: Both read ports return the addressed register's value and tag combinationally, each from its own index, with no effect on each other.
- R10: `rda_ext9` equals {tag, bits 39:32} of the register selected by `rda_idx`, with the tag in bit 8.
- R11: A write leaves every register other than the addressed one unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load port write enable |
| ld_idx | input | 4 | Load target register |
| ld_size | input | 2 | Size code: 00 byte, 01 word, 10 long, 11 none |
| ld_frac | input | 1 | Word operand is fractional |
| ld_signed | input | 1 | Sign-extend (1) or zero-extend (0) |
| ld_data | input | 32 | Load operand |
| alu_en | input | 1 | Arithmetic port write enable |
| alu_idx | input | 4 | Arithmetic target register |
| alu_data | input | 40 | Full register value to write |
| alu_tag | input | 1 | Tag value to write |
| rda_idx | input | 4 | Read port A index |
| rda_data | output | 40 | Read port A value |
| rda_tag | output | 1 | Read port A tag |
| rda_ext9 | output | 9 | Tag and extension byte of port A register |
| rdb_idx | input | 4 | Read port B index |
| rdb_data | output | 40 | Read port B value |
| rdb_tag | output | 1 | Read port B tag |

## Verification
The hardest state to reach from the ports is a load landing on a register whose tag is already set and whose upper bits are non-zero. Only then does a missing tag clear, or a missing high-bit fill, show up. Before every load, the bench therefore presets the target through the arithmetic port with a value of mixed bits and a set tag. It then sweeps every register, size code, flag pair and a set of data patterns at the sign boundaries. Same-cycle collisions of the two ports are driven on purpose to expose the priority.

// File: rtl/dreg_pkg.sv
// Shared parameters and types for the data register file.
// Assumes the size code encoding is fixed as listed in SIZE_E.
package dreg_pkg;
    localparam int EXT_W  = 8;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = 2 * HALF_W;
    localparam int REG_W  = EXT_W + BUS_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_NONE = 2'b11
    } size_e;
endpackage

// File: rtl/dreg_fmt.sv
// Load operand formatter: places a bus operand in its register portion and
// fills the remaining bits. Purely combinational.
// Assumes the caller gates the result with the load enable.
module dreg_fmt
    import dreg_pkg::*;
(
    input  logic [1:0]       size,
    input  logic             frac,
    input  logic             sgn,
    input  logic [BUS_W-1:0] data,
    output logic             ok,
    output logic [REG_W-1:0] value
);
    logic byte_fill;
    logic word_fill;
    logic long_fill;

    // Fill bits for each size: sign copy only when a signed load is asked.
    always_comb begin
        byte_fill = sgn & data[BYTE_W-1];
        word_fill = sgn & data[HALF_W-1];
        long_fill = sgn & data[BUS_W-1];
    end

    // Select placement and extension by size code.
    always_comb begin
        ok    = 1'b1;
        value = '0;
        case (size_e'(size))
            SZ_BYTE: value = {{(REG_W-BYTE_W){byte_fill}}, data[BYTE_W-1:0]};
            SZ_WORD: begin
                if (frac)
                    value = {{EXT_W{data[HALF_W-1]}}, data[HALF_W-1:0], {HALF_W{1'b0}}};
                else
                    value = {{(REG_W-HALF_W){word_fill}}, data[HALF_W-1:0]};
            end
            SZ_LONG: value = {{EXT_W{long_fill}}, data};
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dreg_store.sv
// Register storage with two write ports: a formatted load port and a raw
// arithmetic port that wins on a same-register collision.
// Assumes load value is already formatted; tag is cleared on every load.
module dreg_store
    import dreg_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_we,
    input  logic [IDX_W-1:0]           ld_idx,
    input  logic [REG_W-1:0]           ld_val,
    input  logic                       alu_we,
    input  logic [IDX_W-1:0]           alu_idx,
    input  logic [REG_W-1:0]           alu_val,
    input  logic                       alu_tag,
    output logic [NREG-1:0][REG_W-1:0] val_q,
    output logic [NREG-1:0]            tag_q
);
    logic [NREG-1:0] ld_hit;
    logic [NREG-1:0] alu_hit;

    // Per-register decode of both write ports.
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign ld_hit[g]  = ld_we  && (ld_idx  == IDX_W'(g));
        assign alu_hit[g] = alu_we && (alu_idx == IDX_W'(g));
    end

    // Update storage: reset, then arithmetic port over load port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            tag_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (alu_hit[i]) begin
                    val_q[i] <= alu_val;
                    tag_q[i] <= alu_tag;
                end else if (ld_hit[i]) begin
                    val_q[i] <= ld_val;
                    tag_q[i] <= 1'b0;
                end
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (val_q == '0 && tag_q == '0));

    // R2 R3 R4 R5
    tag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !(alu_we && alu_idx == ld_idx)) |=> !tag_q[$past(ld_idx)]);

    // R8
    alu_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_we |=> (val_q[$past(alu_idx)] == $past(alu_val)
                    && tag_q[$past(alu_idx)] == $past(alu_tag)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_we && !alu_we) |=> ($stable(val_q) && $stable(tag_q)));
endmodule

// File: rtl/dreg_rdport.sv
// One combinational read port over the register array.
// Assumes the index is always within range (NREG a power of two).
module dreg_rdport
    import dreg_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0][REG_W-1:0] val_q,
    input  logic [NREG-1:0]            tag_q,
    input  logic [IDX_W-1:0]           idx,
    output logic [REG_W-1:0]           data,
    output logic                       tag
);
    // Select the indexed register and its tag.
    always_comb begin
        data = val_q[idx];
        tag  = tag_q[idx];
    end
endmodule

// File: rtl/dreg_file.sv
// Top of the data register file: load formatter, storage, two read ports
// and the packed tag/extension view on port A.
// Assumes one load and one arithmetic write at most per cycle.
module dreg_file
    import dreg_pkg::*;
#(
    parameter int NREG  = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [IDX_W-1:0]     ld_idx,
    input  logic [1:0]           ld_size,
    input  logic                 ld_frac,
    input  logic                 ld_signed,
    input  logic [BUS_W-1:0]     ld_data,
    input  logic                 alu_en,
    input  logic [IDX_W-1:0]     alu_idx,
    input  logic [REG_W-1:0]     alu_data,
    input  logic                 alu_tag,
    input  logic [IDX_W-1:0]     rda_idx,
    output logic [REG_W-1:0]     rda_data,
    output logic                 rda_tag,
    output logic [EXT_W:0]       rda_ext9,
    input  logic [IDX_W-1:0]     rdb_idx,
    output logic [REG_W-1:0]     rdb_data,
    output logic                 rdb_tag
);
    logic                       fmt_ok;
    logic [REG_W-1:0]           fmt_val;
    logic [NREG-1:0][REG_W-1:0] val_q;
    logic [NREG-1:0]            tag_q;

    dreg_fmt u_fmt (
        .size  (ld_size),
        .frac  (ld_frac),
        .sgn   (ld_signed),
        .data  (ld_data),
        .ok    (fmt_ok),
        .value (fmt_val)
    );

    dreg_store #(.NREG(NREG)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (ld_en && fmt_ok),
        .ld_idx  (ld_idx),
        .ld_val  (fmt_val),
        .alu_we  (alu_en),
        .alu_idx (alu_idx),
        .alu_val (alu_data),
        .alu_tag (alu_tag),
        .val_q   (val_q),
        .tag_q   (tag_q)
    );

    dreg_rdport #(.NREG(NREG)) u_rda (
        .val_q (val_q),
        .tag_q (tag_q),
        .idx   (rda_idx),
        .data  (rda_data),
        .tag   (rda_tag)
    );

    dreg_rdport #(.NREG(NREG)) u_rdb (
        .val_q (val_q),
        .tag_q (tag_q),
        .idx   (rdb_idx),
        .data  (rdb_data),
        .tag   (rdb_tag)
    );

    // Pack tag above the extension byte for port A.
    always_comb rda_ext9 = {rda_tag, rda_data[REG_W-1 -: EXT_W]};

    // R4
    frac_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_size == SZ_WORD && ld_frac && !(alu_en && alu_idx == ld_idx))
        |=> (val_q[$past(ld_idx)][HALF_W-1:0] == '0
             && val_q[$past(ld_idx)][BUS_W +: EXT_W] == {EXT_W{val_q[$past(ld_idx)][BUS_W-1]}}
             && val_q[$past(ld_idx)][BUS_W-1 -: HALF_W] == $past(ld_data[HALF_W-1:0])));
endmodule

// File: tb/sim_dreg_file.sv
`timescale 1ns/100ps
module sim_dreg_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_frac = 1'b0;
    logic        ld_signed = 1'b0;
    logic [31:0] ld_data = '0;
    logic        alu_en = 1'b0;
    logic [3:0]  alu_idx = '0;
    logic [39:0] alu_data = '0;
    logic        alu_tag = 1'b0;
    logic [3:0]  rda_idx = '0;
    logic [39:0] rda_data;
    logic        rda_tag;
    logic [8:0]  rda_ext9;
    logic [3:0]  rdb_idx = '0;
    logic [39:0] rdb_data;
    logic        rdb_tag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [39:0] m_val [16];
    logic        m_tag [16];

    always #2.5 clk = ~clk;

    dreg_file u0 (.*);

    task automatic chk(string req, logic [40:0] act, logic [40:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected load value computed arithmetically (mod 2^40).
    function automatic logic [39:0] model_ld(logic [1:0] sz, logic fr, logic sg, logic [31:0] d);
        logic [39:0] r;
        case (sz)
            2'b00: begin r = {32'h0, d[7:0]};  if (sg && d[7])  r = r - 40'h100; end
            2'b01: begin
                if (fr) begin r = {8'h0, d[15:0], 16'h0}; if (d[15]) r = r - 40'h1_0000_0000; end
                else begin r = {24'h0, d[15:0]}; if (sg && d[15]) r = r - 40'h1_0000; end
            end
            default: begin r = {8'h0, d}; if (sg && d[31]) r = r - 40'h1_0000_0000; end
        endcase
        return r;
    endfunction

    function automatic string req_of(logic [1:0] sz, logic fr);
        case (sz)
            2'b00: return "R2";
            2'b01: return fr ? "R4" : "R3";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic alu_wr(int idx, logic [39:0] v, logic t);
        @(negedge clk);
        alu_en = 1'b1; alu_idx = 4'(idx); alu_data = v; alu_tag = t;
        @(negedge clk);
        alu_en = 1'b0;
        m_val[idx] = v; m_tag[idx] = t;
    endtask

    task automatic ld_wr(int idx, logic [1:0] sz, logic fr, logic sg, logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_size = sz; ld_frac = fr; ld_signed = sg; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        if (sz != 2'b11) begin m_val[idx] = model_ld(sz, fr, sg, d); m_tag[idx] = 1'b0; end
    endtask

    task automatic look(string req, int a, int b);
        rda_idx = 4'(a); rdb_idx = 4'(b);
        #1;
        chk(req, {rda_tag, rda_data}, {m_tag[a], m_val[a]});
        chk("R10", {32'h0, rda_ext9}, {32'h0, m_tag[a], m_val[a][39:32]});
        chk("R11", {rdb_tag, rdb_data}, {m_tag[b], m_val[b]});
    endtask

    initial begin
        logic [31:0] pats [7];
        pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0080, 32'h0000_8000,
                 32'h8000_0000, 32'h7F7F_7F7F, 32'hA5C3_5A3C};
        for (int i = 0; i < 16; i++) begin m_val[i] = '0; m_tag[i] = 1'b0; end
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) look("R1", i, 15 - i);
        rst_n = 1'b1;

        // Sweep registers, sizes, flags and patterns over a tagged preset.
        for (int r = 0; r < 16; r++)
            for (int sz = 0; sz < 4; sz++)
                for (int f = 0; f < 4; f++)
                    for (int p = 0; p < 7; p++) begin
                        alu_wr(r, 40'hC3_9A5E_71B4 ^ {8'(r), 32'(p)}, 1'b1);
                        look("R7", r, (r + 5) % 16);
                        ld_wr(r, 2'(sz), f[1], f[0], pats[p] ^ (p == 6 ? 32'(r) : 32'h0));
                        look(req_of(2'(sz), f[1]), r, (r + 7 + p) % 16);
                    end

        // Same-register collision: arithmetic port wins.
        for (int r = 0; r < 16; r += 3) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 4'(r); ld_size = 2'b10; ld_frac = 1'b0; ld_signed = 1'b1;
            ld_data = 32'h8765_4321;
            alu_en = 1'b1; alu_idx = 4'(r); alu_data = 40'h5A_0F0F_F0F0; alu_tag = 1'b1;
            @(negedge clk);
            ld_en = 1'b0; alu_en = 1'b0;
            m_val[r] = 40'h5A_0F0F_F0F0; m_tag[r] = 1'b1;
            look("R8", r, (r + 1) % 16);
        end

        // Both ports on different registers in one cycle.
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 4'd2; ld_size = 2'b00; ld_frac = 1'b0; ld_signed = 1'b1; ld_data = 32'h0000_00F0;
        alu_en = 1'b1; alu_idx = 4'd9; alu_data = 40'h01_2345_6789; alu_tag = 1'b0;
        @(negedge clk);
        ld_en = 1'b0; alu_en = 1'b0;
        m_val[2] = 40'hFF_FFFF_FFF0; m_tag[2] = 1'b0;
        m_val[9] = 40'h01_2345_6789; m_tag[9] = 1'b0;
        look("R9", 2, 9);
        look("R9", 9, 2);

        // Reset mid-run clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin m_val[i] = '0; m_tag[i] = 1'b0; end
        for (int i = 0; i < 16; i++) look("R1", i, (i + 3) % 16);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule